// File: doc/BRIEF.md
# SCL Rate Divider

This block derives the bit timing of an I2C master from the system clock. A single eight-bit baud setting carries two divider fields. A three-bit exponent field N selects a power-of-two prescale of 2^(N+1) cycles. A four-bit linear field M then stretches each prescale period by a factor of (M+1). One base interval is therefore 2^(N+1)·(M+1) clock cycles. Ten base intervals make one SCL period, so the SCL rate is the clock rate divided by 10·(M+1)·2^(N+1).

The byte engine consumes two outputs. The first is a quarter-phase tick together with the index of the quarter it opens, which tells the engine where to move SDA and SCL. The second is a free-running reference strobe that pulses once per SCL period, along with a level that is low during the first half of the period and high during the second half. Choosing M and N for a wanted bus speed is left to software.

Changing either field restarts the dividers from zero. Dropping the enable parks the outputs.

Top module: `scl_rate_div`

## Requirements
- R1: The exponent field N is `baud_cfg[2:0]` and the linear field M is `baud_cfg[6:3]`. The base interval B is (M+1)·2^(N+1) clock cycles, and `scl_strobe` pulses every 10·B cycles.
- R2: `scl_strobe` is a one-cycle pulse. With the fields held steady, the first pulse is visible 10·B clock edges after the first edge at which `div_en` is sampled high.
- R3: `qtr_tick` pulses 2·B, 5·B, 7·B and 10·B edges after the period start. After each pulse, `qtr_idx` reads 1, 2, 3 and 0 in turn, and it does not change between ticks.
- R4: `scl_level` is 0 while `qtr_idx` is 0 or 1 and 1 while it is 2 or 3. The low half and the high half of each period each last 5·B cycles.
- R5: The slowest setting (M=15, N=7) gives a period of 40960 clock cycles.
- R6: A change of `baud_cfg[7]` alone has no effect: the dividers keep counting and the strobe period is unchanged.
- R7: A change of any bit in `baud_cfg[6:0]` clears every divider stage and the outputs. The next `scl_strobe` is then visible 10·B+1 edges after the edge that saw the new value.
- R8: While `div_en` is low, `qtr_tick`, `scl_strobe`, `scl_level` and `qtr_idx` are all 0 from the next edge onward. Enabling again restarts the timing as in R2.
- R9: During and right after reset, every output is 0.
- R10: `qtr_tick` never stays high for two cycles in a row. Every `scl_strobe` coincides with a `qtr_tick` that sets `qtr_idx` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_cfg | input | 8 | Baud setting: M in bits 6:3, N in bits 2:0, bit 7 unused |
| div_en | input | 1 | Run enable; low holds the dividers cleared |
| qtr_tick | output | 1 | One-cycle pulse at each quarter boundary of the SCL period |
| qtr_idx | output | 2 | Index of the quarter now running (0..3) |
| scl_level | output | 1 | Reference SCL level: low half 0, high half 1 |
| scl_strobe | output | 1 | One-cycle pulse at the start of each SCL period |

## Verification
The bench measures the exact edge counts of strobe and quarter ticks for several field pairs. A design that swapped the fields or was off by one in either stage would show a wrong period or a start shifted by a cycle. The slowest setting is run in full to catch a prescale counter too narrow for 2^8. A change that only touches bit 7 must leave the period untouched, while a change to M must restart the timing one cycle later than a cold enable. A design that compared the whole byte, or failed to clear, would miss one of these two counts. Dropping the enable mid-period must leave the index and pulses at zero, which catches a design that only gated the outputs and let the counters run on.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  // default layout of the baud setting
  parameter int unsigned DEF_CFG_W  = 8;
  parameter int unsigned DEF_EXP_W  = 3;
  parameter int unsigned DEF_LIN_W  = 4;
  parameter int unsigned DEF_EXP_LSB = 0;
  parameter int unsigned DEF_LIN_LSB = 3;
  // base intervals per SCL period
  parameter int unsigned DEF_SLOTS  = 10;

  typedef logic [1:0] qtr_idx_t;
endpackage

// File: rtl/scl_pow2_stage.sv
module scl_pow2_stage #(
  parameter int unsigned EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [EXP_W-1:0] exp_sel,
  output logic             step
);
  localparam int unsigned CNT_W = 2 ** EXP_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last_val;

  // last count value = 2^(exp+1)-1, i.e. exp+1 low ones
  always_comb begin
    for (int i = 0; i < CNT_W; i++) begin
      last_val[i] = (i <= int'(exp_sel));
    end
  end

  assign step = run && (cnt_q == last_val);

  always_comb begin
    if (!run)      cnt_d = '0;
    else if (step) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/scl_lin_stage.sv
module scl_lin_stage #(
  parameter int unsigned LIN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             step,
  input  logic [LIN_W-1:0] lin_sel,
  output logic             base_tick
);
  logic [LIN_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign base_tick = step && (cnt_q == lin_sel);
  assign cnt_en    = !run || step;

  always_comb begin
    if (!run)           cnt_d = '0;
    else if (base_tick) cnt_d = '0;
    else                cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
  import scl_div_pkg::*;
#(
  parameter int unsigned SLOTS = 10
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  logic     base_tick,
  output logic     qtr_tick,
  output qtr_idx_t qtr_idx,
  output logic     scl_level,
  output logic     scl_strobe
);
  localparam int unsigned SLOT_W = $clog2(SLOTS);
  localparam int unsigned B_Q1   = SLOTS / 4;
  localparam int unsigned B_H    = SLOTS / 2;
  localparam int unsigned B_Q3   = B_H + B_Q1;

  logic [SLOT_W-1:0] slot_q, slot_d, slot_nx;
  qtr_idx_t          idx_q, idx_d, idx_new;
  logic              hit;
  logic              tick_q, tick_d;
  logic              strb_q, strb_d;

  assign slot_nx = (slot_q == SLOT_W'(SLOTS - 1)) ? '0 : slot_q + 1'b1;

  always_comb begin
    hit     = 1'b0;
    idx_new = idx_q;
    if (slot_nx == '0) begin
      hit = 1'b1; idx_new = 2'd0;
    end else if (slot_nx == SLOT_W'(B_Q1)) begin
      hit = 1'b1; idx_new = 2'd1;
    end else if (slot_nx == SLOT_W'(B_H)) begin
      hit = 1'b1; idx_new = 2'd2;
    end else if (slot_nx == SLOT_W'(B_Q3)) begin
      hit = 1'b1; idx_new = 2'd3;
    end
  end

  always_comb begin
    if (!run) begin
      slot_d = '0;
      idx_d  = 2'd0;
      tick_d = 1'b0;
      strb_d = 1'b0;
    end else begin
      slot_d = base_tick ? slot_nx : slot_q;
      idx_d  = (base_tick && hit) ? idx_new : idx_q;
      tick_d = base_tick && hit;
      strb_d = base_tick && (slot_nx == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      idx_q  <= 2'd0;
      tick_q <= 1'b0;
      strb_q <= 1'b0;
    end else begin
      slot_q <= slot_d;
      idx_q  <= idx_d;
      tick_q <= tick_d;
      strb_q <= strb_d;
    end
  end

  assign qtr_tick   = tick_q;
  assign qtr_idx    = idx_q;
  assign scl_level  = idx_q[1];
  assign scl_strobe = strb_q;
endmodule

// File: rtl/scl_rate_div.sv
module scl_rate_div
  import scl_div_pkg::*;
#(
  parameter int unsigned CFG_W   = DEF_CFG_W,
  parameter int unsigned EXP_W   = DEF_EXP_W,
  parameter int unsigned LIN_W   = DEF_LIN_W,
  parameter int unsigned EXP_LSB = DEF_EXP_LSB,
  parameter int unsigned LIN_LSB = DEF_LIN_LSB,
  parameter int unsigned SLOTS   = DEF_SLOTS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] baud_cfg,
  input  logic             div_en,
  output logic             qtr_tick,
  output logic [1:0]       qtr_idx,
  output logic             scl_level,
  output logic             scl_strobe
);
  localparam int unsigned FLD_W = EXP_W + LIN_W;

  logic [EXP_W-1:0] exp_sel;
  logic [LIN_W-1:0] lin_sel;
  logic [FLD_W-1:0] fld_now, fld_q;
  logic             restart, run;
  logic             step, base_tick;
  qtr_idx_t         idx_w;

  assign exp_sel = baud_cfg[EXP_LSB +: EXP_W];
  assign lin_sel = baud_cfg[LIN_LSB +: LIN_W];
  assign fld_now = {lin_sel, exp_sel};

  // a new field value clears every stage for one cycle
  assign restart = (fld_now != fld_q);
  assign run     = div_en && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fld_q <= '0;
    else        fld_q <= fld_now;
  end

  scl_pow2_stage #(.EXP_W(EXP_W)) u_pow2 (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .exp_sel (exp_sel),
    .step    (step)
  );

  scl_lin_stage #(.LIN_W(LIN_W)) u_lin (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .step      (step),
    .lin_sel   (lin_sel),
    .base_tick (base_tick)
  );

  scl_phase_seq #(.SLOTS(SLOTS)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .base_tick  (base_tick),
    .qtr_tick   (qtr_tick),
    .qtr_idx    (idx_w),
    .scl_level  (scl_level),
    .scl_strobe (scl_strobe)
  );

  assign qtr_idx = idx_w;
endmodule

// File: rtl/scl_rate_div_chk.sv
module scl_rate_div_chk #(
  parameter int unsigned CFG_W  = 8,
  parameter int unsigned FLD_HI = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CFG_W-1:0] baud_cfg,
  input logic             div_en,
  input logic             qtr_tick,
  input logic [1:0]       qtr_idx,
  input logic             scl_level,
  input logic             scl_strobe
);
  assert_idle_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !div_en |=> (!qtr_tick && !scl_strobe && qtr_idx == 2'd0 && !scl_level));

  assert_restart_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(baud_cfg[FLD_HI:0]) |=> (qtr_idx == 2'd0 && !scl_strobe && !qtr_tick));

  assert_strobe_on_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    scl_strobe |-> (qtr_tick && qtr_idx == 2'd0));

  assert_tick_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    qtr_tick |=> !qtr_tick);

  assert_idx_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    qtr_tick |-> (qtr_idx == 2'($past(qtr_idx) + 2'd1)));

  assert_idx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !qtr_tick |-> ($stable(qtr_idx) || qtr_idx == 2'd0));
endmodule

bind scl_rate_div scl_rate_div_chk #(.CFG_W(CFG_W), .FLD_HI(LIN_LSB + LIN_W - 1)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .baud_cfg   (baud_cfg),
  .div_en     (div_en),
  .qtr_tick   (qtr_tick),
  .qtr_idx    (qtr_idx),
  .scl_level  (scl_level),
  .scl_strobe (scl_strobe)
);

// File: tb/scl_rate_div_bench.sv
`timescale 1ns/1ps
module scl_rate_div_bench;
  logic       clk;
  logic       rst_n;
  logic [7:0] baud_cfg;
  logic       div_en;
  logic       qtr_tick;
  logic [1:0] qtr_idx;
  logic       scl_level;
  logic       scl_strobe;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  // positions recorded during one measured period
  int t_pos [4];
  int t_idx [4];
  int t_cnt;
  int lvl_pre, lvl_post;

  scl_rate_div u_scl_rate_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_cfg   (baud_cfg),
    .div_en     (div_en),
    .qtr_tick   (qtr_tick),
    .qtr_idx    (qtr_idx),
    .scl_level  (scl_level),
    .scl_strobe (scl_strobe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk_eq(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int base_of(input logic [7:0] c);
    return (int'(c[6:3]) + 1) * (2 ** (int'(c[2:0]) + 1));
  endfunction

  // count negedges until scl_strobe, recording quarter ticks and level
  task automatic count_to_strobe(input int limit, input int b, output int n);
    t_cnt = 0; lvl_pre = -1; lvl_post = -1;
    n = 0;
    for (int k = 1; k <= limit; k++) begin
      @(negedge clk);
      n = k;
      if (qtr_tick && t_cnt < 4) begin
        t_pos[t_cnt] = k;
        t_idx[t_cnt] = int'(qtr_idx);
        t_cnt++;
      end
      if (k == 5 * b - 1) lvl_pre  = int'(scl_level);
      if (k == 5 * b)     lvl_post = int'(scl_level);
      if (scl_strobe) break;
    end
  endtask

  task automatic start_run(input logic [7:0] c);
    @(negedge clk);
    div_en   = 1'b0;
    baud_cfg = c;
    @(negedge clk);
    @(negedge clk);
    div_en = 1'b1;
  endtask

  task automatic t_reset;
    chk_eq("R9", "qtr_tick after reset", qtr_tick, 0);
    chk_eq("R9", "scl_strobe after reset", scl_strobe, 0);
    chk_eq("R9", "qtr_idx after reset", qtr_idx, 0);
    chk_eq("R9", "scl_level after reset", scl_level, 0);
  endtask

  task automatic t_rate(input logic [7:0] c);
    int b, n;
    b = base_of(c);
    start_run(c);
    count_to_strobe(20 * b, b, n);
    chk_eq("R2", $sformatf("first strobe cfg=%h", c), n, 10 * b);
    chk_eq("R3", "tick count in first period", t_cnt, 4);
    chk_eq("R3", "tick 1 position", t_pos[0], 2 * b);
    chk_eq("R3", "tick 2 position", t_pos[1], 5 * b);
    chk_eq("R3", "tick 3 position", t_pos[2], 7 * b);
    chk_eq("R3", "tick 4 position", t_pos[3], 10 * b);
    chk_eq("R3", "idx after tick 1", t_idx[0], 1);
    chk_eq("R3", "idx after tick 2", t_idx[1], 2);
    chk_eq("R3", "idx after tick 3", t_idx[2], 3);
    chk_eq("R10", "idx at strobe", t_idx[3], 0);
    chk_eq("R4", "level before mid-period", lvl_pre, 0);
    chk_eq("R4", "level at mid-period", lvl_post, 1);
    @(negedge clk);
    chk_eq("R2", "strobe width one cycle", scl_strobe, 0);
    count_to_strobe(20 * b, b, n);
    chk_eq("R1", $sformatf("period cfg=%h", c), n + 1, 10 * b);
  endtask

  task automatic t_slow;
    int n;
    start_run(8'h7F);
    count_to_strobe(41000, 4096, n);
    chk_eq("R5", "slowest period", n, 40960);
  endtask

  task automatic t_upper;
    int n;
    start_run(8'h09);
    count_to_strobe(200, 8, n);
    baud_cfg = 8'h89;
    count_to_strobe(200, 8, n);
    chk_eq("R6", "period after bit 7 change", n, 80);
  endtask

  task automatic t_restart;
    int n;
    start_run(8'h09);
    count_to_strobe(200, 8, n);
    repeat (13) @(negedge clk);
    baud_cfg = 8'h01;
    count_to_strobe(200, 4, n);
    chk_eq("R7", "strobe after field change", n, 41);
  endtask

  task automatic t_enable;
    int n, bad;
    start_run(8'h00);
    count_to_strobe(100, 2, n);
    repeat (7) @(negedge clk);
    div_en = 1'b0;
    bad = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (qtr_tick || scl_strobe || scl_level || qtr_idx != 2'd0) bad++;
    end
    chk_eq("R8", "active outputs while disabled", bad, 0);
    div_en = 1'b1;
    count_to_strobe(100, 2, n);
    chk_eq("R8", "first strobe after re-enable", n, 20);
  endtask

  initial begin
    rst_n    = 1'b0;
    div_en   = 1'b0;
    baud_cfg = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rate(8'h00);
    t_rate(8'h0B);
    t_rate(8'h3A);
    t_upper();
    t_restart();
    t_enable();
    t_slow();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule